// File: doc/BRIEF.md
# Reloading Down-Count Timer with APB Access

This block is a 32-bit down-counting timer that sits behind an APB slave port with no wait states. Software sets a reload value and a starting count, then turns counting on. Each time the count steps from 1 to 0 the block latches a pending flag, and it can drive an interrupt line from that flag. On the next count step after reaching 0, the counter reloads itself from the reload register, so it runs as a periodic tick source without software involvement.

A single external input widens its use. It passes through a two-flop synchronizer. It can then either gate counting, so the counter only moves while the input is high, which measures pulse width. Or it can act as the count clock, so the counter steps once per rising edge, which measures frequency. Read data is captured during the APB setup phase and presented, registered, in the access phase. This keeps the read multiplexer off the path to the bus.

Top module: `apb_dntimer`

## Requirements
- R1: After a synchronous reset (active-high `rst`), the control, current-count, reload and pending registers all read zero and `irq` is low. `pready` is always 1 and `pslverr` is always 0.
- R2: The reload register (word offset 0x008) and the current-count register (word offset 0x004) each store and read back a full 32-bit value.
- R3: The control register (offset 0x000) keeps bits [3:0] and reads zero above them: bit 0 run, bit 1 gate by external input, bit 2 count external rising edges, bit 3 interrupt enable. An unmapped offset reads zero.
- R4: With run set and neither external bit set, the count drops by one on every clock. The tick that moves it from 1 to 0 sets the pending flag (bit 0 at offset 0x00C) one clock after that tick is applied.
- R5: A tick applied while the count is 0 loads the reload value instead of decrementing.
- R6: `irq` is high exactly when the pending flag and control bit 3 are both set.
- R7: Writing 1 to bit 0 at offset 0x00C clears the pending flag. Writing 0 there leaves it unchanged.
- R8: A write to the current-count register loads the written value in that cycle. It overrides any decrement or reload, and that cycle raises no pending flag.
- R9: With run and bit 1 set, the counter drops once per clock while the synchronized external input is high and holds while it is low.
- R10: With run and bit 2 set, the counter drops once per rising edge of the synchronized external input. Bit 2 takes priority over bit 1, so a steady high input causes no counting.
- R11: If a 1-to-0 tick and a write-1-to-clear of the pending flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W (12) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data, registered |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | Asynchronous external gate or count clock |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. One is the hardware setting the pending flag on a 1-to-0 tick. The other is a software write-1-to-clear of that flag. The bench loads a count of 3 and enables counting. It then issues the clear write back to back, so that the write lands on the third tick, which is the tick that reaches 0. A read of the pending register afterwards must return 1. The same edge-counting approach aligns a current-count write with a running decrement, and that result is judged by reading back the exact value expected after the later ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word indices of the registers (byte offset >> 2)
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_CUR  = 1;
  localparam int unsigned IDX_RLD  = 2;
  localparam int unsigned IDX_PEND = 3;

  localparam int unsigned CTRL_W = 4;

  // packed: first member is the MSB (bit 3)
  typedef struct packed {
    logic irq_en;    // bit 3
    logic clk_sel;   // bit 2
    logic gate_sel;  // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              pend,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reload,
  output logic              cur_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] prdata
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              wr_stb;
  logic              rd_cap;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_lsb;

  assign idx        = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign wr_stb     = psel & penable & pwrite;
  assign rd_cap     = psel & ~penable & ~pwrite;

  assign cur_wr = wr_stb && (idx == IW'(IDX_CUR));
  assign clr_wr = wr_stb && (idx == IW'(IDX_PEND)) && pwdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (wr_stb) begin
      if (idx == IW'(IDX_CTRL)) ctrl   <= ctrl_t'(pwdata[CTRL_W-1:0]);
      if (idx == IW'(IDX_RLD))  reload <= pwdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (idx == IW'(IDX_CTRL))      rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
    else if (idx == IW'(IDX_CUR))  rd_mux = cnt;
    else if (idx == IW'(IDX_RLD))  rd_mux = reload;
    else if (idx == IW'(IDX_PEND)) rd_mux = {{(DATA_W-1){1'b0}}, pend};
  end

  // sample during setup so the access phase sees a flop output
  always_ff @(posedge clk) begin
    if (rst)         prdata <= '0;
    else if (rd_cap) prdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] reload,
  input  logic              cur_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_wr,
  input  logic              ext_lvl,
  input  logic              ext_rise,
  output logic [DATA_W-1:0] cnt,
  output logic              pend,
  output logic              irq
);
  logic tick;
  logic hit;

  always_comb begin
    if (!ctrl.run)         tick = 1'b0;
    else if (ctrl.clk_sel) tick = ext_rise;
    else if (ctrl.gate_sel) tick = ext_lvl;
    else                   tick = 1'b1;
  end

  assign hit = tick && !cur_wr && (cnt == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cur_wr) begin
      cnt <= wdata;
    end else if (tick) begin
      cnt <= (cnt == '0) ? reload : cnt - DATA_W'(1);
    end
  end

  // setting wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)         pend <= 1'b0;
    else if (hit)    pend <= 1'b1;
    else if (clr_wr) pend <= 1'b0;
  end

  assign irq = pend & ctrl.irq_en;
endmodule

// File: rtl/apb_dntimer.sv
module apb_dntimer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] cnt_q;
  logic              pend_q;
  logic              cur_wr;
  logic              clr_wr;
  logic              ext_lvl;
  logic              ext_rise;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .level(ext_lvl), .rise(ext_rise)
  );

  tmr_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt(cnt_q), .pend(pend_q),
    .ctrl(ctrl_q), .reload(reload_q), .cur_wr(cur_wr), .clr_wr(clr_wr),
    .prdata(prdata)
  );

  tmr_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .reload(reload_q), .cur_wr(cur_wr),
    .wdata(pwdata), .clr_wr(clr_wr), .ext_lvl(ext_lvl), .ext_rise(ext_rise),
    .cnt(cnt_q), .pend(pend_q), .irq(irq)
  );
endmodule

// File: rtl/apb_dntimer_chk.sv
module apb_dntimer_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] reload,
  input logic              pend
);
  localparam int unsigned IW = ADDR_W - 2;

  logic bus_wr;
  logic cur_wr_p;
  logic clr_wr_p;
  logic unused_lsb;

  assign unused_lsb = ^paddr[1:0];
  assign bus_wr   = psel & penable & pwrite;
  assign cur_wr_p = bus_wr && (paddr[ADDR_W-1:2] == IW'(1));
  assign clr_wr_p = bus_wr && (paddr[ADDR_W-1:2] == IW'(3)) && pwdata[0];

  // R4: an unforced change from above 1 is a single decrement
  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(cur_wr_p) && $past(cnt) > DATA_W'(1) && cnt != $past(cnt))
      |-> cnt == $past(cnt) - DATA_W'(1));

  // R4: the pending flag only rises after the count left 1
  assert_pend_from_one_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> ($past(cnt) == DATA_W'(1) && cnt == '0));

  // R5: leaving zero without a bus write means reload
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == '0 && cnt != '0 && !$past(cur_wr_p)) |-> cnt == $past(reload));

  // R7: the flag only falls on a write-one-to-clear
  assert_clear_only_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> $past(clr_wr_p));

  // R8: a count write always lands
  assert_cur_write_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cur_wr_p) |-> cnt == $past(pwdata));
endmodule

bind apb_dntimer apb_dntimer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .cnt(cnt_q), .reload(reload_q), .pend(pend_q)
);

// File: tb/apb_dntimer_test.sv
module apb_dntimer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  logic        ext_in = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  apb_dntimer uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
  );

  // {address, write data, expected read}
  localparam logic [75:0] VEC [0:5] = '{
    {12'h008, 32'hDEADBEEF, 32'hDEADBEEF},  // R2 reload
    {12'h004, 32'h12345678, 32'h12345678},  // R2 count
    {12'h000, 32'hFFFFFFFE, 32'h0000000E},  // R3 control width
    {12'h000, 32'h00000000, 32'h00000000},  // R3
    {12'h00C, 32'h00000001, 32'h00000000},  // R7 clear when clear
    {12'h010, 32'h0000FFFF, 32'h00000000}   // R3 unmapped
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(12'(i * 4), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);

    // vector table: R2 R3
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], d);
      check($sformatf("R2/R3 vector %0d", i), d, VEC[i][31:0]);
    end

    // R4 R5: internal count, 1->0 raises flag, then reload
    wr(12'h008, 32'd5);
    wr(12'h004, 32'd3);
    wr(12'h000, 32'h9);           // run + irq enable at edge P0
    @(negedge clk);               // after P1: 2
    @(negedge clk);               // after P2: 1
    check("R4 irq before zero", {31'h0, irq}, 32'h0);
    @(negedge clk);               // after P3: 0, flag set
    check("R4 irq at 1->0", {31'h0, irq}, 32'h1);
    wr(12'h000, 32'h8);           // P4 ->5, P5 ->4, P6 ->3 and stop
    rd(12'h004, d);
    check("R5 reload then count", d, 32'd3);
    rd(12'h00C, d);
    check("R4 pending flag", d, 32'h1);

    // R6 R7
    wr(12'h000, 32'h0);
    check("R6 irq masked", {31'h0, irq}, 32'h0);
    wr(12'h00C, 32'h0);
    rd(12'h00C, d);
    check("R7 write zero keeps flag", d, 32'h1);
    wr(12'h000, 32'h8);
    check("R6 irq unmasked", {31'h0, irq}, 32'h1);
    wr(12'h00C, 32'h1);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);
    rd(12'h00C, d);
    check("R7 flag cleared", d, 32'h0);

    // R8 count write overrides a running decrement
    wr(12'h000, 32'h1);
    wr(12'h004, 32'd100);
    wr(12'h000, 32'h0);           // 99, 98, 97 then stop
    rd(12'h004, d);
    check("R8 write overrides tick", d, 32'd97);

    // R9 gate mode
    wr(12'h00C, 32'h1);
    wr(12'h004, 32'd50);
    wr(12'h000, 32'h3);
    repeat (5) @(negedge clk);
    rd(12'h004, d);
    check("R9 holds while low", d, 32'd50);
    ext_in = 1'b1;
    repeat (10) @(negedge clk);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    wr(12'h000, 32'h0);
    rd(12'h004, d);
    check("R9 ten gated cycles", d, 32'd40);

    // R10 edge mode
    wr(12'h004, 32'd50);
    wr(12'h000, 32'h5);
    for (int p = 0; p < 7; p++) begin
      ext_in = 1'b1; repeat (3) @(negedge clk);
      ext_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(12'h000, 32'h0);
    rd(12'h004, d);
    check("R10 seven edges", d, 32'd43);
    ext_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(12'h000, 32'h7);
    repeat (10) @(negedge clk);
    rd(12'h004, d);
    check("R10 edge select priority", d, 32'd43);
    wr(12'h000, 32'h0);
    ext_in = 1'b0;

    // R11 set and clear in the same cycle
    wr(12'h00C, 32'h1);
    wr(12'h004, 32'd3);
    wr(12'h000, 32'h1);           // P0; 1->0 tick at P3
    wr(12'h00C, 32'h1);           // clear lands at P3
    wr(12'h000, 32'h0);
    rd(12'h00C, d);
    check("R11 set beats clear", d, 32'h1);

    // R1 reset while running
    wr(12'h000, 32'h9);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(12'(i * 4), d);
      check("R1 register after reset", d, 32'h0);
    end

    finish_run();
  end
endmodule